// File: doc/BRIEF.md
# I2C Slave Address Match and Status Flags

This block sits beside an I2C byte engine on the slave side. It keeps three status flags. The last-received-bit flag holds either the acknowledge value or the final data bit of the last byte. The general-call flag marks a broadcast address. The address-hit flag shows that this node was addressed. The bus engine reports events to the block as single-cycle strobes: START seen, STOP seen, byte finished (with the received byte), and acknowledge clock (with the sampled SDA level).

The address comparator looks only at the first byte after a START or a repeated START. In 7-bit mode it compares the upper seven bits against the own-address register, and a general call also counts as a hit. In 10-bit mode it compares the whole first byte, including the read/write bit. A CPU write to the data shift register or to the transmit buffer clears the last-received-bit flag and the address-hit flag.

The flags are packed into a status byte together with three CPU-writable control bits. The active-low reset is asserted asynchronously and released synchronously through a two-stage synchronizer inside the block.

Top module: `i2c_slave_status`

## Requirements
- R1: On an acknowledge-clock strobe, the last-received-bit flag (status bit 0) takes the sampled SDA level one cycle later: 0 when the receiver acknowledged, 1 when it did not.
- R2: On a byte-finished strobe without an acknowledge-clock strobe in the same cycle, status bit 0 takes bit 0 of the received byte.
- R3: A CPU write strobe to the data shift register or to the transmit buffer clears status bit 0 and the address-hit flag (status bit 2), and leaves the general-call flag (status bit 1) unchanged.
- R4: A first byte equal to 0x00 sets the general-call flag in either addressing mode.
- R5: A START or a STOP strobe clears the general-call flag.
- R6: In 7-bit mode (mode input 0), a first byte whose bits 7..1 equal bits 7..1 of the own address sets status bit 2, whatever its bit 0 is. A general call also sets status bit 2.
- R7: In 10-bit mode (mode input 1), status bit 2 is set only when all 8 bits of the first byte equal the own address. A general call sets status bit 2 only if the own address is 0x00.
- R8: Only the first byte after a START or repeated START is compared. Later bytes, and bytes that arrive before any START, never set status bit 1 or bit 2.
- R9: When a set or update event meets a clearing event in the same cycle, the set or update wins. This covers a CPU write against a byte or acknowledge update, and a START or STOP against a general-call set.
- R10: Status bits 4, 6 and 7 are written from the status write data and read back. Bits 3 and 5 always read 0. A status write never changes bits 0 to 2.
- R11: After reset the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_det | input | 1 | START or repeated START seen (strobe) |
| stop_det | input | 1 | STOP seen (strobe) |
| byte_done | input | 1 | Received byte complete (strobe) |
| rx_byte | input | DATA_W | Byte received, valid with byte_done |
| ack_clk | input | 1 | Acknowledge clock (strobe) |
| ack_sda | input | 1 | SDA level sampled in the acknowledge clock |
| ten_bit_mode | input | 1 | 0: 7-bit addressing, 1: 10-bit first-byte compare |
| own_addr | input | DATA_W | Own-address register value |
| wr_dshift | input | 1 | CPU write to the data shift register (strobe) |
| wr_txbuf | input | 1 | CPU write to the transmit buffer (strobe) |
| wr_status | input | 1 | CPU write to the status byte (strobe) |
| wr_data | input | DATA_W | CPU write data for the status byte |
| status_o | output | DATA_W | Packed status byte |
| lrb_o | output | 1 | Last-received-bit flag |
| gen_call_o | output | 1 | General-call flag |
| addr_hit_o | output | 1 | Address-hit flag |

## Verification
Every flag is a register that drives a port directly, so a wrong internal state shows up one cycle after the strobe that caused it. A first-byte tracker that is stuck set lets a later data byte of 0x00 or an own-address value raise bit 1 or bit 2 on the next clock. A tracker that is stuck clear keeps a matching first byte from ever raising them. Wrong priority between a set and a clear shows up as a flag that reads 0 in the cycle after a CPU write that coincided with a byte. The bench compares the whole status byte against a behavioural model on every clock, so any of these faults is reported in the same cycle it appears.

// File: rtl/i2c_sa_pkg.sv
package i2c_sa_pkg;
  localparam int POS_LRB  = 0;
  localparam int POS_GC   = 1;
  localparam int POS_HIT  = 2;
  localparam int POS_USR0 = 4;
  localparam int POS_USR1 = 6;
  localparam int POS_USR2 = 7;

  typedef enum logic {
    ADDR_7B  = 1'b0,
    ADDR_10B = 1'b1
  } addr_mode_e;

  typedef struct packed {
    logic addr_hit;
    logic gen_call;
    logic lrb;
  } sa_flags_t;
endpackage

// File: rtl/i2c_sa_compare.sv
module i2c_sa_compare
  import i2c_sa_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  addr_mode_e        mode,
  output logic              is_gcall,
  output logic              is_hit
);
  localparam int UPPER_W = ADDR_W - 1;

  logic [ADDR_W-1:0] bit_eq;
  logic              upper_eq;
  logic              full_eq;

  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_eq
    assign bit_eq[gi] = ~(rx_byte[gi] ^ own_addr[gi]);
  end

  assign upper_eq = &bit_eq[ADDR_W-1:ADDR_W-UPPER_W];
  assign full_eq  = &bit_eq;

  always_comb begin
    is_gcall = ~|rx_byte;
    if (mode == ADDR_10B) begin
      is_hit = full_eq;
    end else begin
      is_hit = upper_eq | is_gcall;
    end
  end
endmodule

// File: rtl/i2c_sa_frame.sv
module i2c_sa_frame (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic byte_done,
  output logic first_pend
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = start_det | stop_det | byte_done;
    pend_d  = pend_q;
    if (stop_det | byte_done) pend_d = 1'b0;
    if (start_det)            pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign first_pend = pend_q;

  assert_arm_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> first_pend);

  assert_disarm_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !start_det) |=> !first_pend);
endmodule

// File: rtl/i2c_sa_flags.sv
module i2c_sa_flags
  import i2c_sa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       byte_done,
  input  logic       rx_lsb,
  input  logic       ack_clk,
  input  logic       ack_sda,
  input  logic       cpu_wr,
  input  logic       first_pend,
  input  logic       is_gcall,
  input  logic       is_hit,
  input  addr_mode_e mode,
  output sa_flags_t  flags
);
  sa_flags_t flg_q;
  sa_flags_t flg_d;
  logic      flg_en;
  logic      gc_set;
  logic      hit_set;

  always_comb begin
    gc_set  = byte_done & first_pend & is_gcall;
    hit_set = byte_done & first_pend & is_hit;
    flg_en  = cpu_wr | byte_done | ack_clk | start_det | stop_det;
    flg_d   = flg_q;
    // last received bit: ack clock over byte end over cpu clear
    if (cpu_wr)    flg_d.lrb = 1'b0;
    if (byte_done) flg_d.lrb = rx_lsb;
    if (ack_clk)   flg_d.lrb = ack_sda;
    // general call: set beats start/stop clear
    if (start_det | stop_det) flg_d.gen_call = 1'b0;
    if (gc_set)               flg_d.gen_call = 1'b1;
    // address hit: set beats cpu clear
    if (cpu_wr)  flg_d.addr_hit = 1'b0;
    if (hit_set) flg_d.addr_hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else if (flg_en) begin
      flg_q <= flg_d;
    end
  end

  assign flags = flg_q;

  assert_lrb_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_clk |=> (flags.lrb == $past(ack_sda)));

  assert_lrb_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !ack_clk) |=> (flags.lrb == $past(rx_lsb)));

  assert_cpu_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !ack_clk && !byte_done) |=> (!flags.lrb && !flags.addr_hit));

  assert_gc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_det || stop_det) && !byte_done) |=> !flags.gen_call);

  assert_gcall_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && first_pend && is_gcall && mode == ADDR_7B) |=> flags.addr_hit);

  assert_later_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !first_pend && !cpu_wr) |=> $stable(flags.addr_hit));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && byte_done && first_pend && is_hit) |=> flags.addr_hit);
endmodule

// File: rtl/i2c_slave_status.sv
module i2c_slave_status
  import i2c_sa_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              ack_clk,
  input  logic              ack_sda,
  input  logic              ten_bit_mode,
  input  logic [DATA_W-1:0] own_addr,
  input  logic              wr_dshift,
  input  logic              wr_txbuf,
  input  logic              wr_status,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] status_o,
  output logic              lrb_o,
  output logic              gen_call_o,
  output logic              addr_hit_o
);
  localparam logic [DATA_W-1:0] USR_MASK =
    DATA_W'((1 << POS_USR0) | (1 << POS_USR1) | (1 << POS_USR2));

  logic              rst_meta_q;
  logic              rst_sync_q;
  logic              rst_int_n;
  addr_mode_e        mode;
  logic              first_pend;
  logic              is_gcall;
  logic              is_hit;
  logic              cpu_wr;
  sa_flags_t         flags;
  logic [DATA_W-1:0] usr_q;
  logic [DATA_W-1:0] usr_d;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  assign mode   = addr_mode_e'(ten_bit_mode);
  assign cpu_wr = wr_dshift | wr_txbuf;

  i2c_sa_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .byte_done  (byte_done),
    .first_pend (first_pend)
  );

  i2c_sa_compare #(.ADDR_W(DATA_W)) u_cmp (
    .rx_byte  (rx_byte),
    .own_addr (own_addr),
    .mode     (mode),
    .is_gcall (is_gcall),
    .is_hit   (is_hit)
  );

  i2c_sa_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .byte_done  (byte_done),
    .rx_lsb     (rx_byte[0]),
    .ack_clk    (ack_clk),
    .ack_sda    (ack_sda),
    .cpu_wr     (cpu_wr),
    .first_pend (first_pend),
    .is_gcall   (is_gcall),
    .is_hit     (is_hit),
    .mode       (mode),
    .flags      (flags)
  );

  // cpu-writable control bits
  always_comb begin
    usr_d = wr_data & USR_MASK;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      usr_q <= '0;
    end else if (wr_status) begin
      usr_q <= usr_d;
    end
  end

  always_comb begin
    status_o          = usr_q;
    status_o[POS_LRB] = flags.lrb;
    status_o[POS_GC]  = flags.gen_call;
    status_o[POS_HIT] = flags.addr_hit;
  end

  assign lrb_o      = flags.lrb;
  assign gen_call_o = flags.gen_call;
  assign addr_hit_o = flags.addr_hit;

  assert_status_write_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_status && !start_det && !stop_det && !byte_done && !ack_clk && !cpu_wr)
      |=> $stable(status_o[POS_HIT:POS_LRB]));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_status |=> (status_o[3] == 1'b0 && status_o[5] == 1'b0));
endmodule

// File: tb/i2c_slave_status_tb_top.sv
module i2c_slave_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_det, stop_det, byte_done, ack_clk, ack_sda;
  logic [7:0] rx_byte;
  logic       ten_bit_mode;
  logic [7:0] own_addr;
  logic       wr_dshift, wr_txbuf, wr_status;
  logic [7:0] wr_data;
  logic [7:0] status_o;
  logic       lrb_o, gen_call_o, addr_hit_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  // reference model state
  bit       m_lrb, m_gc, m_hit, m_first;
  bit [7:0] m_usr;

  always #5 clk = ~clk;

  i2c_slave_status dut_i (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .rx_byte(rx_byte), .ack_clk(ack_clk), .ack_sda(ack_sda),
    .ten_bit_mode(ten_bit_mode), .own_addr(own_addr), .wr_dshift(wr_dshift),
    .wr_txbuf(wr_txbuf), .wr_status(wr_status), .wr_data(wr_data),
    .status_o(status_o), .lrb_o(lrb_o), .gen_call_o(gen_call_o), .addr_hit_o(addr_hit_o)
  );

  function automatic bit [7:0] model_status();
    bit [7:0] s;
    s = m_usr;
    s[0] = m_lrb;
    s[1] = m_gc;
    s[2] = m_hit;
    return s;
  endfunction

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    bit first_now, gcall, match;
    if (!rst_n) begin
      m_lrb = 0; m_gc = 0; m_hit = 0; m_first = 0; m_usr = 0;
    end else begin
      first_now = m_first;
      gcall = (rx_byte == 8'h00);
      if (ten_bit_mode) match = (rx_byte == own_addr);
      else match = ((rx_byte >> 1) == (own_addr >> 1)) || gcall;
      if (ack_clk) m_lrb = ack_sda;
      else if (byte_done) m_lrb = rx_byte[0];
      else if (wr_dshift || wr_txbuf) m_lrb = 0;
      if (byte_done && first_now && gcall) m_gc = 1;
      else if (start_det || stop_det) m_gc = 0;
      if (byte_done && first_now && match) m_hit = 1;
      else if (wr_dshift || wr_txbuf) m_hit = 0;
      if (start_det) m_first = 1;
      else if (byte_done || stop_det) m_first = 0;
      if (wr_status) m_usr = wr_data & 8'hD0;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    bit [7:0] exp_s;
    if (cmp_on) begin
      exp_s = model_status();
      n_chk++;
      if (status_o !== exp_s || lrb_o !== exp_s[0] || gen_call_o !== exp_s[1]
          || addr_hit_o !== exp_s[2]) begin
        n_fail++;
        if (status_o[0] !== exp_s[0])
          $display("FAIL R2 per-cycle lrb: actual=%h expected=%h", status_o, exp_s);
        else if (status_o[1] !== exp_s[1])
          $display("FAIL R4 per-cycle gen_call: actual=%h expected=%h", status_o, exp_s);
        else if (status_o[2] !== exp_s[2])
          $display("FAIL R6 per-cycle addr_hit: actual=%h expected=%h", status_o, exp_s);
        else
          $display("FAIL R10 per-cycle status: actual=%h expected=%h", status_o, exp_s);
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic idle();
    start_det = 0; stop_det = 0; byte_done = 0; ack_clk = 0; ack_sda = 0;
    wr_dshift = 0; wr_txbuf = 0; wr_status = 0;
  endtask

  // inputs are set before the call at a falling edge; one rising edge then passes
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_byte = b; byte_done = 1; cyc();
  endtask

  initial begin
    rst_n = 0; idle(); rx_byte = 0; ten_bit_mode = 0; own_addr = 8'hA4; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R11 reset status", status_o, 8'h00);
    cmp_on = 1;

    start_det = 1; cyc();
    send_byte(8'hA5);
    check("R6 7-bit upper match", status_o, 8'h05);
    ack_clk = 1; ack_sda = 0; cyc();
    check("R1 ack returned", status_o, 8'h04);
    ack_clk = 1; ack_sda = 1; cyc();
    check("R1 no ack", status_o, 8'h05);
    send_byte(8'h00);
    check("R8 later byte ignored", status_o, 8'h04);
    wr_dshift = 1; cyc();
    check("R3 shift write clears", status_o, 8'h00);

    start_det = 1; cyc();
    send_byte(8'h00);
    check("R4 general call 7-bit", status_o, 8'h06);
    wr_txbuf = 1; cyc();
    check("R3 gen_call kept", status_o, 8'h02);
    stop_det = 1; cyc();
    check("R5 stop clears gen_call", status_o, 8'h00);
    send_byte(8'hA4);
    check("R8 byte without start", status_o, 8'h00);

    ten_bit_mode = 1;
    start_det = 1; cyc();
    send_byte(8'hA5);
    check("R7 rw bit differs", status_o, 8'h01);
    start_det = 1; cyc();
    check("R5 start clears", status_o, 8'h01);
    send_byte(8'hA4);
    check("R7 full match", status_o, 8'h04);
    wr_txbuf = 1; cyc();
    start_det = 1; cyc();
    send_byte(8'h00);
    check("R7 gcall no hit", status_o, 8'h02);

    start_det = 1; cyc();
    rx_byte = 8'hA4; byte_done = 1; wr_dshift = 1; cyc();
    check("R9 hit beats cpu clear", status_o, 8'h04);
    ack_clk = 1; ack_sda = 1; wr_txbuf = 1; cyc();
    check("R9 ack beats cpu clear", status_o, 8'h01);
    start_det = 1; cyc();
    rx_byte = 8'h00; byte_done = 1; stop_det = 1; cyc();
    check("R9 gcall beats stop", status_o, 8'h02);

    wr_status = 1; wr_data = 8'hFF; cyc();
    check("R10 writable bits", status_o, 8'hD2);
    wr_status = 1; wr_data = 8'h00; cyc();
    check("R10 clear writable bits", status_o, 8'h02);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      start_det = (r < 10);
      stop_det  = (r >= 95);
      byte_done = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 3))
        0: rx_byte = own_addr;
        1: rx_byte = own_addr ^ 8'h01;
        2: rx_byte = 8'h00;
        default: rx_byte = 8'($urandom);
      endcase
      ack_clk   = ($urandom_range(0, 4) == 0);
      ack_sda   = 1'($urandom);
      wr_dshift = ($urandom_range(0, 9) == 0);
      wr_txbuf  = ($urandom_range(0, 9) == 0);
      wr_status = ($urandom_range(0, 15) == 0);
      wr_data   = 8'($urandom);
      if ($urandom_range(0, 49) == 0) ten_bit_mode = ~ten_bit_mode;
      cyc();
    end

    cmp_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule